// File: doc/BRIEF.md
# Frame-Preemption Verify Handshake Controller

This block runs the verification exchange that one Ethernet port must complete before it may send preemptible traffic. When released from its held state, it sends verify requests to the transmit path, times each one in wire-side clock cycles, and watches the receive path for the partner's answer. The result is reported on four separate status flags. The controller also answers verify requests that arrive from the partner by issuing a respond request.

Software restarts the exchange by raising the link-fail control input and then lowering it again. The timeout and the verify-bypass input are sampled at the moment of release. The requested 8-bit preemptible-class mask, with one bit per traffic class, reaches the output only after verification has succeeded or has been bypassed. Until then the output mask is zero. With a 125 MHz wire clock, a 10 ms timeout is 0x1312D0 cycles, and this value fits the default 24-bit counter field.

Top module: `mac_merge_verify`

## Requirements
- R1: While `link_fail_i` is 1, and from the clock after it rises, all four status flags, `tx_verify_o` and `pmask_o` are 0. Any state gathered earlier is cleared.
- R2: After release with verification enabled and a valid timeout, `tx_verify_o` pulses for exactly one cycle. The pulse appears one clock after the first edge that samples `link_fail_i` low.
- R3: With no response, verify pulses repeat every T+1 cycles, where T is the sampled timeout. There are at most 3 pulses in total.
- R4: If no response arrives, `st_vfy_failed_o` goes to 1 T+1 cycles after the third pulse. It stays at 1 until link-fail is raised.
- R5: A `rx_respond_i` strobe while a verify pulse is outstanding sets `st_verified_o` on the next cycle. No further verify pulses follow.
- R6: `pmask_o` is 0 unless the port is verified or bypassed. Once it is, `pmask_o` follows `pmask_req_i` cycle by cycle, with bit i standing for traffic class i.
- R7: If `verify_off_i` is 1 at release, no verify pulse is sent and all status flags stay 0. `pmask_o` carries the requested mask from the next cycle.
- R8: A timeout of 0, or one above 2^24-1, sets `st_vfy_err_o` on the cycle after release. In that case no verify pulse is sent. The value 2^24-1 itself is accepted.
- R9: Each cycle in which `rx_verify_i` is 1 outside the held state produces exactly one `tx_respond_o` pulse, one cycle later. In the held state it produces none.
- R10: A `rx_respond_i` strobe while no verify is outstanding, outside the held state, sets the sticky `st_resp_err_o` flag and leaves the other flags as they were. In the held state the strobe is ignored.
- R11: At most one of verified, verify-failed and verify-error is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rst | input | 1 | Synchronous active-high reset |
| link_fail_i | input | 1 | 1 holds the controller in reset; a falling edge starts verification |
| verify_off_i | input | 1 | Skip the handshake and apply the mask directly |
| pmask_req_i | input | 8 | Requested preemptible-class mask |
| timeout_i | input | 32 | Timeout interval in wire clocks, sampled at release |
| rx_verify_i | input | 1 | Strobe: a verify frame arrived from the partner |
| rx_respond_i | input | 1 | Strobe: a respond frame arrived from the partner |
| st_verified_o | output | 1 | Verification succeeded |
| st_vfy_failed_o | output | 1 | All attempts timed out |
| st_resp_err_o | output | 1 | Unexpected respond frame seen |
| st_vfy_err_o | output | 1 | Timeout value rejected |
| tx_verify_o | output | 1 | Strobe: send one verify frame |
| tx_respond_o | output | 1 | Strobe: send one respond frame |
| pmask_o | output | 8 | Active preemptible-class mask |

## Verification
The assertions assume that `verify_off_i` and `timeout_i` change only while `link_fail_i` is high. The mask-gating property depends on the bypass input staying steady once released. The receive strobes are also assumed to be one-cycle events. The stimulus follows these rules: it sets the bypass and the timeout values only inside a restart window, while link-fail is held. It drives each receive strobe for a single cycle at a clock's falling edge.

// File: rtl/mmv_pkg.sv
package mmv_pkg;

    localparam int unsigned MV_CFG_W = 32;

    typedef enum logic [2:0] {
        MV_HOLD,
        MV_SEND,
        MV_WAIT,
        MV_PASS,
        MV_FAIL,
        MV_BYPASS,
        MV_BADCFG
    } mv_state_e;

    typedef struct packed {
        logic verified;
        logic vfy_failed;
        logic resp_err;
        logic vfy_err;
    } mv_status_t;

    // A timeout is usable when nonzero and it fits a counter of w bits.
    function automatic logic mv_timeout_fits(input logic [MV_CFG_W-1:0] t,
                                             input int unsigned w);
        logic [MV_CFG_W-1:0] hi;
        hi = (w >= MV_CFG_W) ? '0 : (t >> w);
        return (t != '0) && (hi == '0);
    endfunction

endpackage

// File: rtl/mmv_timer.sv
module mmv_timer #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expire = run && (cnt_q == W'(1));

    // The sequencer only runs the timer after loading a nonzero interval.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q != '0));

endmodule

// File: rtl/mmv_responder.sv
module mmv_responder (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rx_verify,
    output logic tx_respond
);
    logic resp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= 1'b0;
        end else begin
            resp_q <= enable && rx_verify;
        end
    end

    assign tx_respond = resp_q;

endmodule

// File: rtl/mmv_fsm.sv
module mmv_fsm
    import mmv_pkg::*;
#(
    parameter int unsigned TMO_W = 24,
    parameter int unsigned TRIES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_fail,
    input  logic                 verify_off,
    input  logic [MV_CFG_W-1:0]  timeout,
    input  logic                 rx_respond,
    input  logic                 expire,
    output logic                 tmr_load,
    output logic [TMO_W-1:0]     tmr_val,
    output logic                 tmr_run,
    output logic                 send_verify,
    output logic                 in_hold,
    output logic                 mask_open,
    output mv_status_t           status
);
    localparam int unsigned TRY_W = $clog2(TRIES + 1);

    mv_state_e        state_q;
    logic [TRY_W-1:0] tries_q;
    logic [TMO_W-1:0] tmo_q;
    logic             resp_err_q;
    logic             cfg_ok;

    assign cfg_ok = mv_timeout_fits(timeout, TMO_W);

    always_ff @(posedge clk) begin
        if (rst || link_fail) begin
            state_q    <= MV_HOLD;
            tries_q    <= '0;
            tmo_q      <= '0;
            resp_err_q <= 1'b0;
        end else begin
            case (state_q)
                MV_HOLD: begin
                    if (verify_off) begin
                        state_q <= MV_BYPASS;
                    end else if (!cfg_ok) begin
                        state_q <= MV_BADCFG;
                    end else begin
                        tmo_q   <= timeout[TMO_W-1:0];
                        state_q <= MV_SEND;
                    end
                end
                MV_SEND: begin
                    tries_q <= tries_q + TRY_W'(1);
                    state_q <= MV_WAIT;
                end
                MV_WAIT: begin
                    if (rx_respond) begin
                        state_q <= MV_PASS;
                    end else if (expire) begin
                        state_q <= (tries_q == TRY_W'(TRIES)) ? MV_FAIL : MV_SEND;
                    end
                end
                default: ;
            endcase
            if (rx_respond && (state_q != MV_WAIT) && (state_q != MV_HOLD)) begin
                resp_err_q <= 1'b1;
            end
        end
    end

    assign tmr_load    = (state_q == MV_SEND);
    assign tmr_val     = tmo_q;
    assign tmr_run     = (state_q == MV_WAIT);
    assign send_verify = (state_q == MV_SEND);
    assign in_hold     = (state_q == MV_HOLD);
    assign mask_open   = (state_q == MV_PASS) || (state_q == MV_BYPASS);

    assign status.verified   = (state_q == MV_PASS);
    assign status.vfy_failed = (state_q == MV_FAIL);
    assign status.resp_err   = resp_err_q;
    assign status.vfy_err    = (state_q == MV_BADCFG);

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (rst)
        send_verify |=> !send_verify);

    assert_fail_after_wait_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status.vfy_failed) |-> $past(tmr_run) && $past(expire));

    assert_pass_needs_resp_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(status.verified) |-> $past(rx_respond) && $past(tmr_run));

endmodule

// File: rtl/mac_merge_verify.sv
module mac_merge_verify
    import mmv_pkg::*;
#(
    parameter int unsigned TMO_W  = 24,
    parameter int unsigned MASK_W = 8,
    parameter int unsigned TRIES  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_fail_i,
    input  logic                 verify_off_i,
    input  logic [MASK_W-1:0]    pmask_req_i,
    input  logic [MV_CFG_W-1:0]  timeout_i,
    input  logic                 rx_verify_i,
    input  logic                 rx_respond_i,
    output logic                 st_verified_o,
    output logic                 st_vfy_failed_o,
    output logic                 st_resp_err_o,
    output logic                 st_vfy_err_o,
    output logic                 tx_verify_o,
    output logic                 tx_respond_o,
    output logic [MASK_W-1:0]    pmask_o
);
    logic             tmr_load;
    logic [TMO_W-1:0] tmr_val;
    logic             tmr_run;
    logic             tmr_expire;
    logic             in_hold;
    logic             mask_open;
    mv_status_t       status;

    mmv_fsm #(.TMO_W(TMO_W), .TRIES(TRIES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .link_fail   (link_fail_i),
        .verify_off  (verify_off_i),
        .timeout     (timeout_i),
        .rx_respond  (rx_respond_i),
        .expire      (tmr_expire),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_run     (tmr_run),
        .send_verify (tx_verify_o),
        .in_hold     (in_hold),
        .mask_open   (mask_open),
        .status      (status)
    );

    mmv_timer #(.W(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expire   (tmr_expire)
    );

    mmv_responder u_resp (
        .clk        (clk),
        .rst        (rst),
        .enable     (!in_hold),
        .rx_verify  (rx_verify_i),
        .tx_respond (tx_respond_o)
    );

    assign pmask_o         = mask_open ? pmask_req_i : '0;
    assign st_verified_o   = status.verified;
    assign st_vfy_failed_o = status.vfy_failed;
    assign st_resp_err_o   = status.resp_err;
    assign st_vfy_err_o    = status.vfy_err;

    assert_hold_clears_R1: assert property (@(posedge clk) disable iff (rst)
        link_fail_i |=> (!st_verified_o && !st_vfy_failed_o && !st_resp_err_o &&
                         !st_vfy_err_o && !tx_verify_o && (pmask_o == '0)));

    assert_mask_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (pmask_o != '0) |-> (st_verified_o || verify_off_i));

    assert_respond_cause_R9: assert property (@(posedge clk) disable iff (rst)
        tx_respond_o |-> ($past(rx_verify_i) && !$past(link_fail_i)));

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({st_verified_o, st_vfy_failed_o, st_vfy_err_o}) <= 1);

endmodule

// File: tb/sim_mac_merge_verify.sv
module sim_mac_merge_verify;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_fail = 1'b1;
    logic        verify_off = 1'b0;
    logic [7:0]  pmask_req = 8'h00;
    logic [31:0] timeout = 32'd0;
    logic        rx_verify = 1'b0;
    logic        rx_respond = 1'b0;
    logic        st_verified, st_vfy_failed, st_resp_err, st_vfy_err;
    logic        tx_verify, tx_respond;
    logic [7:0]  pmask;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tmo_cur = 0;
    bit finished = 0;
    int exp_v[$];
    int exp_r[$];

    always #4 clk = ~clk;

    mac_merge_verify u0 (
        .clk             (clk),
        .rst             (rst),
        .link_fail_i     (link_fail),
        .verify_off_i    (verify_off),
        .pmask_req_i     (pmask_req),
        .timeout_i       (timeout),
        .rx_verify_i     (rx_verify),
        .rx_respond_i    (rx_respond),
        .st_verified_o   (st_verified),
        .st_vfy_failed_o (st_vfy_failed),
        .st_resp_err_o   (st_resp_err),
        .st_vfy_err_o    (st_vfy_err),
        .tx_verify_o     (tx_verify),
        .tx_respond_o    (tx_respond),
        .pmask_o         (pmask)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected strobe cycles as the design produces strobes.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (tx_verify) begin
                if (exp_v.size() == 0) check(0, "R3 unexpected verify strobe", cyc, -1);
                else begin
                    int e;
                    e = exp_v.pop_front();
                    check(e == cyc, "R2 verify strobe cycle", cyc, e);
                end
            end
            if (tx_respond) begin
                if (exp_r.size() == 0) check(0, "R9 unexpected respond strobe", cyc, -1);
                else begin
                    int e;
                    e = exp_r.pop_front();
                    check(e == cyc, "R9 respond strobe cycle", cyc, e);
                end
            end
        end
    end

    function automatic int flags();
        return {28'd0, st_verified, st_vfy_failed, st_resp_err, st_vfy_err};
    endfunction

    task automatic release_link(input int pulses, output int c0);
        @(negedge clk);
        c0 = cyc;
        link_fail = 1'b0;
        for (int k = 0; k < pulses; k++) exp_v.push_back(c0 + 1 + k * (tmo_cur + 1));
    endtask

    task automatic restart();
        @(negedge clk);
        link_fail = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_respond();
        rx_respond = 1'b1;
        @(negedge clk);
        rx_respond = 1'b0;
    endtask

    task automatic pulse_verify();
        if (!link_fail) exp_r.push_back(cyc + 1);
        rx_verify = 1'b1;
        @(negedge clk);
        rx_verify = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(flags() == 0 && pmask == 0 && !tx_verify, "R1 reset state", flags(), 0);

        tmo_cur = 20;
        timeout = 32'd20;
        pmask_req = 8'hA5;

        // Strobes while held are ignored.
        pulse_verify();
        pulse_respond();
        check(!st_resp_err && !tx_respond, "R10 held strobes ignored", flags(), 0);

        // No response: three attempts then failure.
        release_link(3, c0);
        wait_to(c0 + 5);
        pulse_verify();
        wait_to(c0 + 3 * tmo_cur + 3);
        check(!st_vfy_failed && pmask == 0, "R4 not failed early", flags(), 0);
        @(negedge clk);
        check(st_vfy_failed, "R4 failed after third timeout", flags(), 4);
        check(pmask == 0, "R6 mask closed on fail", pmask, 0);
        repeat (2 * tmo_cur) @(negedge clk);
        check(st_vfy_failed && exp_v.size() == 0, "R3 exactly three attempts", exp_v.size(), 0);

        // Response during the second wait.
        restart();
        check(flags() == 0 && pmask == 0, "R1 restart clears status", flags(), 0);
        release_link(2, c0);
        wait_to(c0 + tmo_cur + 5);
        check(pmask == 0, "R6 mask closed while waiting", pmask, 0);
        pulse_respond();
        check(st_verified && !st_resp_err, "R5 verified after response", flags(), 8);
        check(pmask == 8'hA5, "R6 mask applied when verified", pmask, 8'hA5);
        pmask_req = 8'h3C;
        @(negedge clk);
        check(pmask == 8'h3C, "R6 mask follows request", pmask, 8'h3C);
        repeat (2 * tmo_cur) @(negedge clk);
        check(exp_v.size() == 0, "R5 no strobes after verified", exp_v.size(), 0);
        pulse_respond();
        check(st_resp_err && st_verified, "R10 unexpected response flagged", flags(), 10);
        check($countones({st_verified, st_vfy_failed, st_vfy_err}) == 1, "R11 exclusive flags", flags(), 10);
        pulse_verify();
        pulse_verify();
        repeat (2) @(negedge clk);
        check(exp_r.size() == 0, "R9 respond strobes issued", exp_r.size(), 0);

        // Bypass.
        restart();
        check(!st_resp_err, "R10 sticky error cleared by link-fail", flags(), 0);
        verify_off = 1'b1;
        pmask_req = 8'h81;
        release_link(0, c0);
        @(negedge clk);
        check(pmask == 8'h81 && flags() == 0, "R7 bypass applies mask", pmask, 8'h81);
        repeat (tmo_cur + 4) @(negedge clk);
        check(exp_v.size() == 0 && flags() == 0, "R7 no verify in bypass", flags(), 0);

        // Timeout bounds.
        restart();
        verify_off = 1'b0;
        timeout = 32'h0100_0000;
        release_link(0, c0);
        @(negedge clk);
        check(st_vfy_err && !st_verified && pmask == 0, "R8 oversize timeout rejected", flags(), 1);
        repeat (5) @(negedge clk);
        restart();
        timeout = 32'd0;
        release_link(0, c0);
        @(negedge clk);
        check(st_vfy_err, "R8 zero timeout rejected", flags(), 1);
        restart();
        timeout = 32'h00FF_FFFF;
        release_link(1, c0);
        @(negedge clk);
        check(!st_vfy_err && tx_verify, "R8 largest timeout accepted", flags(), 0);
        repeat (3) @(negedge clk);
        link_fail = 1'b1;
        @(negedge clk);
        check(flags() == 0 && !tx_verify && pmask == 0, "R1 link-fail aborts wait", flags(), 0);
        repeat (4) @(negedge clk);
        check(exp_v.size() == 0 && exp_r.size() == 0, "R2 all strobes accounted", exp_v.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule